// File: doc/BRIEF.md
# Flag-Preserving Rotate-Right Execution Slice

This block is one execution slice of a general-purpose integer pipeline. It rotates a source operand right by a count taken from an 8-bit immediate, and it never reads or alters the arithmetic flags. Operand width is chosen from the processor's execution mode and a width bit of the encoding. The count is masked to that width. Encodings that are not allowed, and modes that do not support the operation, raise an invalid-opcode fault in place of a result.

A request is presented for one cycle with `valid_i` high. One clock edge later the slice shows either a write-enable with the destination value or a fault strobe. The flags bus is re-registered every cycle and so mirrors the incoming flags with one cycle of delay, whatever the request does.

Top module: `flagsafe_rotr`

## Requirements
- R1: With 32-bit operand size, the count is `imm_i & 0x1F`, `dest_o[31:0]` is `src_i[31:0]` rotated right by that count, and `dest_o[63:32]` is zero.
- R2: With 64-bit operand size, the count is `imm_i & 0x3F` and `dest_o` is `src_i` rotated right by that count.
- R3: The operand size is 64 only when `mode_i` is 3 (64-bit mode) and `wide_bit_i` is 1. In modes 2 (protected/compatibility), 1 and 0 the size is 32 and `wide_bit_i` has no effect.
- R4: When `vl_bit_i` is 1, a valid request raises `illop_o` and leaves `wr_en_o` low, in every mode.
- R5: When `mode_i` is 0 (real) or 1 (virtual-8086), a valid request raises `illop_o` and leaves `wr_en_o` low.
- R6: Outside reset, `flags_o` equals the `flags_i` of the previous clock edge in every cycle, faulting requests included.
- R7: A masked count of zero returns the source unchanged (the low 32 bits, zero-extended, in 32-bit size).
- R8: Outputs change one clock edge after the request. `wr_en_o` and `illop_o` are never high together, both are low after a cycle with `valid_i` low, and `dest_o` is zero whenever `wr_en_o` is low.
- R9: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_i | input | 64 | Source operand |
| imm_i | input | 8 | Immediate rotate count |
| vl_bit_i | input | 1 | Vector-length bit of the encoding; must be 0 |
| wide_bit_i | input | 1 | Width bit of the encoding |
| mode_i | input | 2 | Mode: 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| flags_i | input | 8 | Incoming arithmetic flags |
| dest_o | output | 64 | Destination value |
| wr_en_o | output | 1 | Destination write enable |
| illop_o | output | 1 | Invalid-opcode fault strobe |
| flags_o | output | 8 | Flags, passed through unchanged |

## Verification
A short table of fixed vectors uses one source with several immediates. They separate the two masks: 0x44 and 0x3F in 64-bit size, 0x20 and 0x40 giving zero counts, and protected mode with the width bit set, which must stay 32-bit. A sweep of all 256 immediates in both sizes with random sources compares against a shift-and-OR model. It exposes wrong masking, a missing wrap of the high bits, and upper bits that leak in 32-bit size. All sixteen combinations of the vector-length bit, the width bit and the mode check that fault and write stay exclusive and that the flags pass through unchanged when a fault is raised.

// File: rtl/frot_pkg.sv
// Shared definitions for the flag-preserving rotate slice.
// Assumes the mode field is two bits wide and encoded as below.
package frot_pkg;
    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_VM86 = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } exec_mode_e;
endpackage

// File: rtl/frot_decode.sv
// Operand-size and legality decode.
// Picks the wide size only in 64-bit mode with the width bit set. Flags a
// fault for a non-zero vector-length bit or for real / virtual-8086 mode.
// Purely combinational.
module frot_decode
    import frot_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       wide_bit,
    input  logic       vl_bit,
    output logic       use_wide,
    output logic       illegal
);
    exec_mode_e mode_e;

    // Purpose: classify the request by mode and encoding bits.
    always_comb begin
        mode_e   = exec_mode_e'(mode);
        use_wide = (mode_e == MODE_LONG) && wide_bit;
        illegal  = vl_bit || (mode_e == MODE_REAL) || (mode_e == MODE_VM86);
    end
endmodule

// File: rtl/frot_rotator.sv
// Rotate-right lane of width W.
// The count is masked to log2(W) bits. The rotation takes a slice of the
// source concatenated with itself, so no shift by the full width is needed.
// Assumes W is a power of two no larger than 2**CNT_W.
module frot_rotator #(
    parameter int W     = 64,
    parameter int CNT_W = 8
) (
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] imm,
    output logic [W-1:0]     res
);
    localparam logic [CNT_W-1:0] CNT_MASK = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [2*W-1:0]   dbl;

    // Purpose: mask the count and rotate through the doubled source.
    always_comb begin
        cnt = imm & CNT_MASK;
        dbl = {src, src} >> cnt;
        res = dbl[W-1:0];
    end

    // R7: a zero masked count must hand back the source untouched.
    always_comb begin
        if (cnt == '0) begin
            a_r7_zero_count: assert (res == src)
                else $error("zero count changed operand");
        end
    end
endmodule

// File: rtl/frot_outreg.sv
// Output register stage.
// Captures the result or the fault one edge after the request. The flags are
// re-registered every cycle. Reset is synchronous and active low.
module frot_outreg #(
    parameter int DATA_W = 64,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              illegal,
    input  logic [DATA_W-1:0] result,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] dest_q,
    output logic              wr_en_q,
    output logic              fault_q,
    output logic [FLAG_W-1:0] flags_q
);
    // Purpose: register either the result or the fault strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q  <= '0;
            wr_en_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            wr_en_q <= valid && !illegal;
            fault_q <= valid && illegal;
            dest_q  <= (valid && !illegal) ? result : '0;
        end
    end

    // Purpose: carry the flags past the slice unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_in;
    end

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_q && fault_q));
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(valid) |-> !wr_en_q && !fault_q);
    a_r8_dest_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_q |-> dest_q == '0);
    a_r6_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> flags_q == $past(flags_in));
endmodule

// File: rtl/flagsafe_rotr.sv
// Top of the flag-preserving rotate-right slice.
// Decodes size and legality, runs a narrow and a full-width rotate lane, and
// selects one of them into the output register. It assumes DATA_W is even
// and a power of two, and that the request is held for one cycle.
module flagsafe_rotr #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CNT_W-1:0]  imm_i,
    input  logic              vl_bit_i,
    input  logic              wide_bit_i,
    input  logic [1:0]        mode_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] dest_o,
    output logic              wr_en_o,
    output logic              illop_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int LANES    = 2;

    logic              use_wide;
    logic              illegal;
    logic [DATA_W-1:0] lane_res [LANES];
    logic [DATA_W-1:0] result;

    frot_decode u_dec (
        .mode     (mode_i),
        .wide_bit (wide_bit_i),
        .vl_bit   (vl_bit_i),
        .use_wide (use_wide),
        .illegal  (illegal)
    );

    // Lane 0 handles the narrow size, lane 1 the full width.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;
        logic [LW-1:0] lres;
        frot_rotator #(.W(LW), .CNT_W(CNT_W)) u_rot (
            .src (src_i[LW-1:0]),
            .imm (imm_i),
            .res (lres)
        );
        assign lane_res[g] = DATA_W'(lres);
    end

    // Purpose: pick the lane for the decoded operand size.
    always_comb begin
        result = use_wide ? lane_res[1] : lane_res[0];
    end

    frot_outreg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid_i),
        .illegal  (illegal),
        .result   (result),
        .flags_in (flags_i),
        .dest_q   (dest_o),
        .wr_en_q  (wr_en_o),
        .fault_q  (illop_o),
        .flags_q  (flags_o)
    );

    a_r4_vl_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(valid_i && vl_bit_i) |-> illop_o && !wr_en_o);
    a_r5_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(valid_i && !mode_i[1]) |-> illop_o && !wr_en_o);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && wr_en_o && !$past(use_wide)
            |-> dest_o[DATA_W-1:NARROW_W] == '0);
    a_r3_narrow_modes: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i != 2'd3 |-> !use_wide);
endmodule

// File: tb/sim_flagsafe_rotr.sv
`timescale 1ns/1ps
module sim_flagsafe_rotr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] src_i = '0;
    logic [7:0]  imm_i = '0;
    logic        vl_bit_i = 1'b0;
    logic        wide_bit_i = 1'b0;
    logic [1:0]  mode_i = 2'd3;
    logic [7:0]  flags_i = '0;
    logic [63:0] dest_o;
    logic        wr_en_o;
    logic        illop_o;
    logic [7:0]  flags_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flagsafe_rotr u0 (.*);

    localparam int NV = 8;
    localparam logic [63:0] SRC = 64'h0123456789ABCDEF;
    localparam logic [7:0]  V_IMM  [NV] = '{8'h04, 8'h04, 8'h44, 8'h20, 8'h40, 8'h01, 8'h3F, 8'h08};
    localparam logic        V_WIDE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [1:0]  V_MODE [NV] = '{2'd3, 2'd3, 2'd3, 2'd2, 2'd3, 2'd2, 2'd3, 2'd0};
    localparam logic [63:0] V_EXP  [NV] = '{64'hF0123456789ABCDE, 64'h00000000F89ABCDE,
        64'hF0123456789ABCDE, 64'h0000000089ABCDEF, 64'h0123456789ABCDEF,
        64'h00000000C4D5E6F7, 64'h02468ACF13579BDE, 64'h0};
    localparam logic        V_WR   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam string       V_TAG  [NV] = '{"R2", "R1", "R2", "R7", "R7", "R3", "R2", "R5"};

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] s, input logic [7:0] imm, input bit wide);
        logic [31:0] s32;
        int c;
        if (wide) begin
            c = int'(imm) % 64;
            return (c == 0) ? s : ((s >> c) | (s << (64 - c)));
        end
        s32 = s[31:0];
        c = int'(imm) % 32;
        return (c == 0) ? {32'h0, s32} : {32'h0, (s32 >> c) | (s32 << (32 - c))};
    endfunction

    // Drives one request for one cycle and samples the registered result.
    task automatic issue(input logic [63:0] s, input logic [7:0] imm, input logic w,
                         input logic [1:0] m, input logic l, input logic [7:0] f);
        @(negedge clk);
        valid_i = 1'b1; src_i = s; imm_i = imm; wide_bit_i = w;
        mode_i = m; vl_bit_i = l; flags_i = f;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        // R9: reset clears the outputs even with a legal request present.
        issue(SRC, 8'h04, 1'b1, 2'd3, 1'b0, 8'hA5);
        check("R9 dest", dest_o, 64'h0);
        check("R9 wr_en", {63'h0, wr_en_o}, 64'h0);
        check("R9 fault", {63'h0, illop_o}, 64'h0);
        check("R9 flags", {56'h0, flags_o}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fixed vector table.
        for (int i = 0; i < NV; i++) begin
            issue(SRC, V_IMM[i], V_WIDE[i], V_MODE[i], 1'b0, 8'(i * 17));
            check(V_TAG[i], dest_o, V_EXP[i]);
            check({V_TAG[i], " wr"}, {63'h0, wr_en_o}, {63'h0, V_WR[i]});
            check("R6 flags", {56'h0, flags_o}, {56'h0, 8'(i * 17)});
        end

        // Sweep every immediate in both sizes with random sources (R1, R2).
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 256; k++) begin
                logic [63:0] s;
                s = {$urandom, $urandom};
                issue(s, 8'(k), 1'(w), 2'd3, 1'b0, 8'(k));
                check(w ? "R2 sweep" : "R1 sweep", dest_o, model(s, 8'(k), w != 0));
                check("R8 wr", {63'h0, wr_en_o}, 64'h1);
            end
        end

        // Every fault combination of vector-length bit, width bit and mode (R4, R5, R8, R6).
        for (int l = 0; l < 2; l++) begin
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 4; m++) begin
                    bit flt;
                    flt = (l != 0) || (m < 2);
                    issue(SRC, 8'h10, 1'(w), 2'(m), 1'(l), 8'hC3 ^ 8'(m));
                    check(l ? "R4 fault" : "R5 fault", {63'h0, illop_o}, {63'h0, flt});
                    check("R8 wr excl", {63'h0, wr_en_o}, {63'h0, !flt});
                    check("R8 dest", dest_o, flt ? 64'h0 :
                          model(SRC, 8'h10, (m == 3) && (w != 0)));
                    check("R6 flags fault", {56'h0, flags_o}, {56'h0, 8'hC3 ^ 8'(m)});
                end
            end
        end

        // R8: idle cycle with valid low leaves both strobes low.
        @(negedge clk);
        flags_i = 8'h5A;
        @(negedge clk);
        check("R8 idle wr", {63'h0, wr_en_o}, 64'h0);
        check("R8 idle fault", {63'h0, illop_o}, 64'h0);
        check("R8 idle dest", dest_o, 64'h0);
        check("R6 idle flags", {56'h0, flags_o}, 64'h5A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule